// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit with Compare Flags

This block is a purely combinational integer ALU made of identical one-bit slices. Each slice forms the AND, the OR and the full-adder sum of its operand bits at the same time, and a small per-bit multiplexer passes one of them to the result. Carries ripple from each slice into the next. A negate control, carried in the top bit of the operation code, inverts operand B and forces the first carry-in high, so the same adder chain subtracts.

Signed comparison reuses the subtract path. The top slice's sum bit, corrected by the signed overflow condition, gives the true sign of A minus B. That bit is routed back to the Less input of bit 0, so a set-less-than result is right even when the subtraction wraps. A zero flag ORs every result bit and inverts the outcome, which lets an equality branch test A minus B. A front-end multiplexer picks operand B from a register value or from a 16-bit immediate, and the immediate is widened by either sign or zero extension.

Top module: `ripple_alu`

## Requirements
- R1: Operation code 000 returns the bitwise AND of A and operand B.
- R2: Operation code 001 returns the bitwise OR of A and operand B.
- R3: Operation code 010 returns A plus operand B modulo 2^32, and carry_out equals the carry out of bit 31 of that addition.
- R4: Operation code 110 returns A minus operand B modulo 2^32, formed as A + ~B + 1, and carry_out is 1 exactly when no borrow occurs (A >= B unsigned).
- R5: Operation code 111 returns 1 in bit 0 when A is less than operand B as signed two's complement values, and 0 otherwise. Bits 31 to 1 are always 0. The result stays correct when A minus B overflows.
- R6: ovf_flag is 1 for codes 010 and 110 exactly when the signed result cannot be represented: for an add, both operands share a sign that the sum lacks; for a subtract, the operands differ in sign and the difference's sign differs from A's. ovf_flag is 0 for codes 000, 001, 100, 101 and 111.
- R7: zero_flag is 1 exactly when all 32 result bits are 0.
- R8: With use_imm = 0, operand B is reg_b and imm_in has no effect. With use_imm = 1, operand B is imm_in in bits 15..0. Bits 31..16 are copies of imm_in bit 15 when imm_signed = 1, and zeros when imm_signed = 0.
- R9: Top bit of the operation code inverts operand B for the logic selects too: code 100 returns A AND NOT B, and code 101 returns A OR NOT B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code; bit 2 negates B, bits 1..0 pick AND, OR, sum or less |
| a_in | input | 32 | Operand A |
| reg_b | input | 32 | Register value for operand B |
| imm_in | input | 16 | Immediate value for operand B |
| use_imm | input | 1 | 1 selects the extended immediate as operand B |
| imm_signed | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| result | output | 32 | Selected result |
| zero_flag | output | 1 | 1 when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The bench targets signed comparison where the subtraction overflows, such as the most negative value against a positive one. A design that takes the raw sign bit of the difference would invert the answer there. It also drives operand pairs of like sign through subtract and of unlike sign through add, at the representable limits. An overflow detector that looks only at the carry out would raise the flag falsely or miss it at those limits. Immediates with bit 15 set are applied under both extension modes, which exposes a swapped or missing replication. Equal operands drive subtract, and the zero flag must rise there, which catches a flag taken from the wrong signal. Finally, inverted-logic codes with a nonzero carry-in check that the negated B, not the raw one, reaches the logic gates.

// File: rtl/alu_pkg.sv
// Shared operation codes and field positions for the ripple ALU.
package alu_pkg;
    // Operation codes; bit 2 negates operand B and feeds the first carry-in.
    localparam logic [2:0] OP_AND = 3'b000;
    localparam logic [2:0] OP_OR  = 3'b001;
    localparam logic [2:0] OP_ADD = 3'b010;
    localparam logic [2:0] OP_SUB = 3'b110;
    localparam logic [2:0] OP_SLT = 3'b111;
    localparam logic [2:0] OP_ANDN = 3'b100;
    localparam logic [2:0] OP_ORN  = 3'b101;

    // Per-slice output selector in op bits 1..0.
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    localparam int NEG_BIT = 2;
endpackage

// File: rtl/alu_bit_slice.sv
// One bit of the ALU: AND, OR and full-adder sum are formed in parallel,
// then a 4-way mux picks one. Assumes b_neg_i is common to all slices.
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       b_neg_i,
    input  logic       carry_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       carry_o
);
    logic b_eff;
    logic and_v;
    logic or_v;
    logic sum_v;

    // Form all candidate results at once.
    always_comb begin
        b_eff   = b_i ^ b_neg_i;
        and_v   = a_i & b_eff;
        or_v    = a_i | b_eff;
        sum_v   = a_i ^ b_eff ^ carry_i;
        carry_o = (a_i & b_eff) | (a_i & carry_i) | (b_eff & carry_i);
    end

    // Output mux controlled by the slice selector.
    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_o = and_v;
            SEL_OR:   res_o = or_v;
            SEL_SUM:  res_o = sum_v;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_operand_sel.sv
// Chooses operand B from a register or a widened immediate.
// Assumes WIDTH > IMM_W.
module alu_operand_sel #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [WIDTH-1:0] reg_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             sext_i,
    output logic [WIDTH-1:0] opnd_o
);
    localparam int EXT_W = WIDTH - IMM_W;

    logic             fill_bit;
    logic [WIDTH-1:0] imm_wide;

    // Widen the immediate by sign or zero fill, then pick the source.
    always_comb begin
        fill_bit = sext_i & imm_i[IMM_W-1];
        imm_wide = {{EXT_W{fill_bit}}, imm_i};
        opnd_o   = use_imm_i ? imm_wide : reg_i;
    end
endmodule

// File: rtl/alu_msb_flags.sv
// Signed overflow and corrected sign of the top slice. Overflow is the
// disagreement of carry into and out of the MSB; the set bit is the MSB
// sum corrected by that overflow, so it is the true sign of A - B.
module alu_msb_flags (
    input  logic a_msb_i,
    input  logic b_msb_i,
    input  logic b_neg_i,
    input  logic carry_in_msb_i,
    input  logic carry_out_msb_i,
    output logic ovf_o,
    output logic set_o
);
    logic sum_msb;

    // Recompute the MSB sum and derive both flags.
    always_comb begin
        sum_msb = a_msb_i ^ (b_msb_i ^ b_neg_i) ^ carry_in_msb_i;
        ovf_o   = carry_in_msb_i ^ carry_out_msb_i;
        set_o   = sum_msb ^ ovf_o;
    end
endmodule

// File: rtl/ripple_alu.sv
// Top of the ripple-carry ALU: operand mux, WIDTH replicated slices with a
// carry chain, MSB flag logic feeding bit 0's Less input, and a zero detect.
// Purely combinational; no clock or reset.
module ripple_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] reg_b,
    input  logic [IMM_W-1:0] imm_in,
    input  logic             use_imm,
    input  logic             imm_signed,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag,
    output logic             carry_out
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] opnd_b;
    logic             carry_c [WIDTH+1];
    logic             b_neg;
    slice_sel_e       sel;
    logic             ovf_raw;
    logic             set_w;

    // Decode the operation code into negate and selector fields.
    always_comb begin
        b_neg      = op_sel[NEG_BIT];
        sel        = slice_sel_e'(op_sel[1:0]);
        carry_c[0] = b_neg;
    end

    alu_operand_sel #(
        .WIDTH (WIDTH),
        .IMM_W (IMM_W)
    ) u_opsel (
        .reg_i     (reg_b),
        .imm_i     (imm_in),
        .use_imm_i (use_imm),
        .sext_i    (imm_signed),
        .opnd_o    (opnd_b)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_w;
        if (i == 0) begin : g_lsb
            assign less_w = set_w;
        end else begin : g_upper
            assign less_w = 1'b0;
        end

        alu_bit_slice u_slice (
            .a_i     (a_in[i]),
            .b_i     (opnd_b[i]),
            .b_neg_i (b_neg),
            .carry_i (carry_c[i]),
            .less_i  (less_w),
            .sel_i   (sel),
            .res_o   (result[i]),
            .carry_o (carry_c[i+1])
        );
    end

    alu_msb_flags u_msb (
        .a_msb_i         (a_in[MSB]),
        .b_msb_i         (opnd_b[MSB]),
        .b_neg_i         (b_neg),
        .carry_in_msb_i  (carry_c[MSB]),
        .carry_out_msb_i (carry_c[WIDTH]),
        .ovf_o           (ovf_raw),
        .set_o           (set_w)
    );

    // Flags: zero as NOR of the result, overflow only for the sum select.
    always_comb begin
        zero_flag = ~|result;
        ovf_flag  = (sel == SEL_SUM) & ovf_raw;
        carry_out = carry_c[WIDTH];
    end
endmodule

// File: rtl/alu_checker.sv
// Property checker for ripple_alu, attached by bind. Uses immediate
// assertions because the ALU has no clock.
module alu_checker
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] reg_b,
    input logic [IMM_W-1:0] imm_in,
    input logic             use_imm,
    input logic             imm_signed,
    input logic [WIDTH-1:0] result,
    input logic             zero_flag,
    input logic             ovf_flag
);
    logic [WIDTH-1:0] b_ref;

    // Reference operand B for the checks below.
    always_comb begin
        if (!use_imm)        b_ref = reg_b;
        else if (imm_signed) b_ref = WIDTH'($signed(imm_in));
        else                 b_ref = WIDTH'(imm_in);
    end

    // Immediate checks of result and flag relations.
    always_comb begin
        if (op_sel == OP_ADD)
            AST_ADD_SUM: assert (result == a_in + b_ref); // R3
        if (op_sel == OP_SUB)
            AST_SUB_DIFF: assert (result == a_in - b_ref); // R4
        if (op_sel == OP_SLT)
            AST_SLT_VALUE: assert (result == {{(WIDTH-1){1'b0}}, ($signed(a_in) < $signed(b_ref))}); // R5
        if (op_sel == OP_ADD && a_in[WIDTH-1] != b_ref[WIDTH-1])
            AST_NO_OVERFLOW: assert (!ovf_flag); // R6
        if (op_sel == OP_SUB && a_in[WIDTH-1] == b_ref[WIDTH-1])
            AST_SUB_NO_OVERFLOW: assert (!ovf_flag); // R6
        if (op_sel[1] == 1'b0 || op_sel == OP_SLT)
            AST_LOGIC_OVF_LOW: assert (!ovf_flag); // R6
        if (op_sel == OP_SUB)
            AST_ZERO_EQUAL: assert (zero_flag == (a_in == b_ref)); // R7
    end
endmodule

bind ripple_alu alu_checker #(
    .WIDTH (WIDTH),
    .IMM_W (IMM_W)
) u_alu_checker (
    .op_sel     (op_sel),
    .a_in       (a_in),
    .reg_b      (reg_b),
    .imm_in     (imm_in),
    .use_imm    (use_imm),
    .imm_signed (imm_signed),
    .result     (result),
    .zero_flag  (zero_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/tb_ripple_alu.sv
module tb_ripple_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = 3'b000;
    logic [31:0] a_in = '0;
    logic [31:0] reg_b = '0;
    logic [15:0] imm_in = '0;
    logic        use_imm = 1'b0;
    logic        imm_signed = 1'b0;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_flag;
    logic        carry_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ripple_alu dut (
        .op_sel     (op_sel),
        .a_in       (a_in),
        .reg_b      (reg_b),
        .imm_in     (imm_in),
        .use_imm    (use_imm),
        .imm_signed (imm_signed),
        .result     (result),
        .zero_flag  (zero_flag),
        .ovf_flag   (ovf_flag),
        .carry_out  (carry_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive on a rising edge; outputs are read on the following falling edge.
    task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] rb,
                         input logic ui, input logic [15:0] im, input logic sx);
        @(posedge clk);
        op_sel = op; a_in = a; reg_b = rb; use_imm = ui; imm_in = im; imm_signed = sx;
        @(negedge clk);
    endtask

    task automatic t_reset;
        @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset result", result, 32'h0);
        check("R7 reset zero", {31'b0, zero_flag}, 32'h1);
    endtask

    task automatic t_logic;
        apply(3'b000, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 16'h0, 1'b0);
        check("R1 and", result, 32'h00F0_1200);
        check("R6 and ovf", {31'b0, ovf_flag}, 32'h0);
        apply(3'b001, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 16'h0, 1'b0);
        check("R2 or", result, 32'hFFF0_FF34);
        check("R6 or ovf", {31'b0, ovf_flag}, 32'h0);
    endtask

    task automatic t_add;
        apply(3'b010, 32'h0000_0007, 32'h0000_0005, 1'b0, 16'h0, 1'b0);
        check("R3 add small", result, 32'h0000_000C);
        check("R3 add carry low", {31'b0, carry_out}, 32'h0);
        apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 16'h0, 1'b0);
        check("R3 add wrap", result, 32'h0);
        check("R3 add carry high", {31'b0, carry_out}, 32'h1);
        check("R6 add mixed signs", {31'b0, ovf_flag}, 32'h0);
        check("R7 zero after wrap", {31'b0, zero_flag}, 32'h1);
    endtask

    task automatic t_sub;
        apply(3'b110, 32'd12, 32'd5, 1'b0, 16'h0, 1'b0);
        check("R4 sub", result, 32'd7);
        check("R4 sub no borrow", {31'b0, carry_out}, 32'h1);
        apply(3'b110, 32'd5, 32'd12, 1'b0, 16'h0, 1'b0);
        check("R4 sub negative", result, 32'hFFFF_FFF9);
        check("R4 sub borrow", {31'b0, carry_out}, 32'h0);
        check("R7 nonzero", {31'b0, zero_flag}, 32'h0);
        apply(3'b110, 32'h1234_5678, 32'h1234_5678, 1'b0, 16'h0, 1'b0);
        check("R7 equal zero", {31'b0, zero_flag}, 32'h1);
    endtask

    task automatic t_overflow;
        apply(3'b010, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 16'h0, 1'b0);
        check("R6 add pos ovf", {31'b0, ovf_flag}, 32'h1);
        apply(3'b010, 32'h8000_0000, 32'h8000_0000, 1'b0, 16'h0, 1'b0);
        check("R6 add neg ovf", {31'b0, ovf_flag}, 32'h1);
        check("R3 add neg carry", {31'b0, carry_out}, 32'h1);
        apply(3'b110, 32'h8000_0000, 32'h0000_0001, 1'b0, 16'h0, 1'b0);
        check("R6 sub ovf", {31'b0, ovf_flag}, 32'h1);
        apply(3'b110, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 16'h0, 1'b0);
        check("R6 sub same sign", {31'b0, ovf_flag}, 32'h0);
    endtask

    task automatic t_slt;
        apply(3'b111, 32'hFFFF_FFFE, 32'h0000_0003, 1'b0, 16'h0, 1'b0);
        check("R5 slt neg<pos", result, 32'h1);
        apply(3'b111, 32'h0000_0003, 32'hFFFF_FFFE, 1'b0, 16'h0, 1'b0);
        check("R5 slt pos<neg", result, 32'h0);
        apply(3'b111, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, 16'h0, 1'b0);
        check("R5 slt ovf case true", result, 32'h1);
        check("R6 slt ovf low", {31'b0, ovf_flag}, 32'h0);
        apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 16'h0, 1'b0);
        check("R5 slt ovf case false", result, 32'h0);
        apply(3'b111, 32'd9, 32'd9, 1'b0, 16'h0, 1'b0);
        check("R5 slt equal", result, 32'h0);
    endtask

    task automatic t_imm;
        apply(3'b010, 32'h0000_0010, 32'hDEAD_BEEF, 1'b1, 16'hFFFF, 1'b1);
        check("R8 sext add", result, 32'h0000_000F);
        apply(3'b010, 32'h0000_0010, 32'hDEAD_BEEF, 1'b1, 16'hFFFF, 1'b0);
        check("R8 zext add", result, 32'h0001_000F);
        apply(3'b001, 32'h0, 32'h0, 1'b1, 16'h8001, 1'b1);
        check("R8 sext pattern", result, 32'hFFFF_8001);
        apply(3'b001, 32'h0, 32'h0000_00A5, 1'b0, 16'hFFFF, 1'b1);
        check("R8 imm ignored", result, 32'h0000_00A5);
    endtask

    task automatic t_inverted_logic;
        apply(3'b100, 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b0, 16'h0, 1'b0);
        check("R9 and not", result, 32'hF000_F000);
        check("R6 andn ovf", {31'b0, ovf_flag}, 32'h0);
        apply(3'b101, 32'h0000_0000, 32'h0F0F_0F0F, 1'b0, 16'h0, 1'b0);
        check("R9 or not", result, 32'hF0F0_F0F0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_logic();
        t_add();
        t_sub();
        t_overflow();
        t_slt();
        t_imm();
        t_inverted_logic();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule